// File: doc/BRIEF.md
# Subroutine and Interrupt Stack Sequencer

This block is the control unit that moves a 16-bit program counter to and from a byte-wide memory stack in an 8-bit processor. It runs four sequences. A call saves a return address and jumps to a target. A return restores the saved address and jumps back. A software break saves the address, latches a one-byte service selector and vectors to a handler. A hardware interrupt, either maskable or non-maskable, saves the address and vectors to its handler. The stack sits in page 1 and has an 8-bit pointer. The block drives an address, a write-data bus and a write strobe, and it captures read data in the same cycle it presents an address.

The saved return address is deliberately short of the next instruction. A call stacks the opcode address plus one, which is the value the counter holds during the operand fetch. A return then adds two, starting with the low byte and rippling the carry into the high byte inside the same cycle. A break stacks the opcode address plus two. The handler can read the skipped byte on `brk_sel`, so software has 256 selectable services. Every vector address has all of bits 15..3 set. The sequencer supplies only the lowest three bits.

Top module: `callstack_seq`

## Requirements
- R1: While `rst_n` is low, SP is 0xFF and `idis` is 1. After release, PC is loaded from 0xFFFC (low byte) and then 0xFFFD (high byte). `done` pulses in the cycle after the second rising edge that follows release.
- R2: With `op_valid` and `op_class`=1 (call), the block writes (opcode address + 1) to 0x0100+SP, high byte first and then low byte. SP is decremented after each write and PC becomes {`opr_hi`,`opr_lo`}. The sequence is busy for 6 cycles and ends with `done`.
- R3: `op_class`=2 (return) pre-increments SP, reads the low byte and then the high byte, and sets PC to the popped value + 2. The carry goes from the low byte into the high byte. The sequence is busy for 6 cycles.
- R4: SP wraps inside page 1. A push at SP=0x00 writes 0x0100 and leaves SP at 0xFF. A pop at SP=0xFF reads 0x0100.
- R5: `op_class`=3 (break) reads the byte at opcode address + 1 and shows it on `brk_sel`. It then pushes opcode address + 2 (high, then low) and a status byte. The status byte has bit 5 set, bit 4 (break) set and bit 2 equal to the prior `idis`. The sequence sets `idis`, loads PC from 0xFFFE/0xFFFF and is busy for 7 cycles.
- R6: A low `irq_n` seen while idle with `idis`=0 pushes the current PC (high, then low) and a status byte with bit 4 clear. It then sets `idis`, loads PC from 0xFFFE/0xFFFF and is busy for 7 cycles.
- R7: While `idis`=1, a low `irq_n` starts nothing and leaves PC unchanged.
- R8: A falling edge on `nmi_n` enters like R6 but loads PC from 0xFFFA/0xFFFB, whatever the value of `idis`. It wins over a simultaneous IRQ. Holding `nmi_n` low does not cause a second entry.
- R9: `op_class`=0 with `op_valid` starts no sequence and leaves PC unchanged.
- R10: `idis_clr` clears `idis` while the block is idle.
- R11: Writes only go to page 1. `done` is a one-cycle pulse. Every vector fetch address has bits 15..3 all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start a sequence of class `op_class` (taken only while idle) |
| op_class | input | 2 | 0 none, 1 call, 2 return, 3 break |
| opr_lo | input | 8 | Call target low byte |
| opr_hi | input | 8 | Call target high byte |
| irq_n | input | 1 | Maskable interrupt request, active low, level |
| nmi_n | input | 1 | Non-maskable interrupt, active low, falling edge |
| idis_clr | input | 1 | Clear the interrupt-disable flag |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, valid in the cycle the address is shown |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer (page 1 offset) |
| idis | output | 1 | Interrupt-disable flag |
| brk_sel | output | 8 | Service selector latched by the last break |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Final cycle of a sequence |

## Verification
The assertions assume two things. First, `op_valid` is raised only for a single cycle while the block is idle. Second, memory read data depends only on the address shown in the same cycle, so the stack and vector contents are stable between a write and the read that follows. The stimulus respects both: it issues each operation from a task and waits for `done` before starting the next one. It also changes the interrupt lines only while the block is idle, except for the case where `nmi_n` is deliberately held low to show that it does not retrigger. When IRQ and NMI are raised together, both edges land in the same idle cycle, so that cycle decides the priority.

// File: rtl/callstack_pkg.sv
`timescale 1ns/1ps
package callstack_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int VEC_LOW_W  = 3;

    typedef enum logic [1:0] {
        OPC_NONE = 2'd0,
        OPC_CALL = 2'd1,
        OPC_RET  = 2'd2,
        OPC_BRK  = 2'd3
    } opc_e;

    // low vector bits [2:1]; bit 0 picks the byte
    typedef enum logic [1:0] {
        VS_NMI = 2'b01,
        VS_RST = 2'b10,
        VS_IRQ = 2'b11
    } vsel_e;

    typedef enum logic [4:0] {
        S_IDLE, S_RVL, S_RVH,
        S_CALL1, S_CALL2, S_JMP,
        S_ENT, S_PUSHH, S_PUSHL, S_PUSHP,
        S_VECL, S_VECH,
        S_RINC1, S_RPOPL, S_RINC2, S_RPOPH, S_RADJ,
        S_FIN
    } state_e;

    typedef enum logic [1:0] {
        AS_PC, AS_PC_NEXT, AS_STACK, AS_VECTOR
    } asrc_e;

    typedef struct packed {
        state_e              st;
        logic [ADDR_W-1:0]   pc;
        logic [BYTE_W-1:0]   sp;
        logic [ADDR_W-1:0]   tgt;
        logic [ADDR_W-1:0]   pop;
        logic [BYTE_W-1:0]   sel;
        logic                idis;
        logic                brk;
        logic                ent;
        vsel_e               vsel;
    } seq_regs_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic brk, input logic idis);
        status_byte = 8'h20 | {3'b000, brk, 1'b0, idis, 2'b00};
    endfunction

endpackage

// File: rtl/cs_nmi_edge.sv
`timescale 1ns/1ps
module cs_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic ack,
    output logic take
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_regs_t;

    nmi_regs_t n_d, n_q;
    logic      act;
    logic      fall;

    always_comb begin
        act      = ~nmi_n;              // inverted before use
        fall     = act & ~n_q.prev;
        take     = n_q.pend | fall;
        n_d.prev = act;
        n_d.pend = (n_q.pend | fall) & ~ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end
endmodule

// File: rtl/cs_byte_adder.sv
`timescale 1ns/1ps
module cs_byte_adder #(
    parameter int NBYTES = 2,
    parameter int BW     = 8
) (
    input  logic [NBYTES*BW-1:0] a,
    input  logic [BW-1:0]        inc,
    output logic [NBYTES*BW-1:0] y
);
    logic [NBYTES-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        logic [BW-1:0] addend;
        if (i == 0) begin : g_lsb
            assign addend = inc;
        end else begin : g_upper
            assign addend = '0;
        end
        if (i < NBYTES - 1) begin : g_carry
            logic [BW:0] sum;
            assign sum              = {1'b0, a[i*BW +: BW]} + {1'b0, addend} + {{BW{1'b0}}, cy[i]};
            assign y[i*BW +: BW]    = sum[BW-1:0];
            assign cy[i+1]          = sum[BW];
        end else begin : g_top
            assign y[i*BW +: BW]    = a[i*BW +: BW] + addend + {{(BW-1){1'b0}}, cy[i]};
        end
    end
endmodule

// File: rtl/cs_bus_addr.sv
`timescale 1ns/1ps
module cs_bus_addr
    import callstack_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STK_PAGE = 8'h01
) (
    input  asrc_e               src,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [BYTE_W-1:0]   sp,
    input  vsel_e               vsel,
    input  logic                vbyte,
    output logic [ADDR_W-1:0]   addr
);
    localparam int HI_ONES = ADDR_W - VEC_LOW_W;

    always_comb begin
        case (src)
            AS_PC_NEXT: addr = pc + ADDR_W'(1);
            AS_STACK:   addr = ADDR_W'({STK_PAGE, sp});
            AS_VECTOR:  addr = {{HI_ONES{1'b1}}, vsel, vbyte};
            default:    addr = pc;
        endcase
    end
endmodule

// File: rtl/callstack_seq.sv
`timescale 1ns/1ps
module callstack_seq
    import callstack_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STK_PAGE = 8'h01,
    parameter logic [BYTE_W-1:0] SP_INIT  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_class,
    input  logic [BYTE_W-1:0] opr_lo,
    input  logic [BYTE_W-1:0] opr_hi,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              idis_clr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [BYTE_W-1:0] sp,
    output logic              idis,
    output logic [BYTE_W-1:0] brk_sel,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] CALL_ADV = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] BRK_ADV  = ADDR_W'(2);
    localparam logic [BYTE_W-1:0] RET_ADJ  = BYTE_W'(2);

    seq_regs_t         r_d, r_q;
    asrc_e             asrc;
    logic              vbyte;
    logic              nmi_ack;
    logic              nmi_take;
    logic              irq_act;
    logic [ADDR_W-1:0] ret_sum;
    state_e            st_w;

    assign irq_act = ~irq_n;            // inverted before use

    cs_nmi_edge u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .ack   (nmi_ack),
        .take  (nmi_take)
    );

    cs_byte_adder #(.NBYTES(ADDR_BYTES), .BW(BYTE_W)) u_ret_add (
        .a   (r_q.pop),
        .inc (RET_ADJ),
        .y   (ret_sum)
    );

    cs_bus_addr #(.STK_PAGE(STK_PAGE)) u_addr (
        .src   (asrc),
        .pc    (r_q.pc),
        .sp    (r_q.sp),
        .vsel  (r_q.vsel),
        .vbyte (vbyte),
        .addr  (mem_addr)
    );

    always_comb begin
        r_d       = r_q;
        asrc      = AS_PC;
        vbyte     = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        nmi_ack   = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (idis_clr) r_d.idis = 1'b0;
                if (nmi_take) begin
                    r_d.st   = S_ENT;
                    r_d.vsel = VS_NMI;
                    r_d.brk  = 1'b0;
                    r_d.ent  = 1'b1;
                    nmi_ack  = 1'b1;
                end else if (irq_act && !r_q.idis) begin
                    r_d.st   = S_ENT;
                    r_d.vsel = VS_IRQ;
                    r_d.brk  = 1'b0;
                    r_d.ent  = 1'b1;
                end else if (op_valid) begin
                    case (opc_e'(op_class))
                        OPC_CALL: begin
                            r_d.st  = S_CALL1;
                            r_d.tgt = {opr_hi, opr_lo};
                            r_d.ent = 1'b0;
                        end
                        OPC_RET:  r_d.st = S_RINC1;
                        OPC_BRK: begin
                            r_d.st   = S_ENT;
                            r_d.vsel = VS_IRQ;
                            r_d.brk  = 1'b1;
                            r_d.ent  = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            S_RVL: begin
                asrc                 = AS_VECTOR;
                r_d.pc[BYTE_W-1:0]   = mem_rdata;
                r_d.st               = S_RVH;
            end
            S_RVH: begin
                asrc                      = AS_VECTOR;
                vbyte                     = 1'b1;
                r_d.pc[ADDR_W-1:BYTE_W]   = mem_rdata;
                r_d.st                    = S_FIN;
            end
            S_CALL1: begin                  // operand low fetch: PC = opcode + 1
                r_d.pc = r_q.pc + CALL_ADV;
                r_d.st = S_CALL2;
            end
            S_CALL2: r_d.st = S_PUSHH;      // operand high fetch, PC held
            S_ENT: begin
                if (r_q.brk) begin
                    asrc    = AS_PC_NEXT;
                    r_d.sel = mem_rdata;
                    r_d.pc  = r_q.pc + BRK_ADV;
                end
                r_d.st = S_PUSHH;
            end
            S_PUSHH: begin
                asrc      = AS_STACK;
                mem_we    = 1'b1;
                mem_wdata = r_q.pc[ADDR_W-1:BYTE_W];
                r_d.sp    = r_q.sp - 8'd1;
                r_d.st    = S_PUSHL;
            end
            S_PUSHL: begin
                asrc      = AS_STACK;
                mem_we    = 1'b1;
                mem_wdata = r_q.pc[BYTE_W-1:0];
                r_d.sp    = r_q.sp - 8'd1;
                r_d.st    = r_q.ent ? S_PUSHP : S_JMP;
            end
            S_PUSHP: begin
                asrc      = AS_STACK;
                mem_we    = 1'b1;
                mem_wdata = status_byte(r_q.brk, r_q.idis);
                r_d.sp    = r_q.sp - 8'd1;
                r_d.idis  = 1'b1;
                r_d.st    = S_VECL;
            end
            S_VECL: begin
                asrc               = AS_VECTOR;
                r_d.pc[BYTE_W-1:0] = mem_rdata;
                r_d.st             = S_VECH;
            end
            S_VECH: begin
                asrc                    = AS_VECTOR;
                vbyte                   = 1'b1;
                r_d.pc[ADDR_W-1:BYTE_W] = mem_rdata;
                r_d.st                  = S_FIN;
            end
            S_JMP: begin
                r_d.pc = r_q.tgt;
                r_d.st = S_FIN;
            end
            S_RINC1: begin
                r_d.sp = r_q.sp + 8'd1;
                r_d.st = S_RPOPL;
            end
            S_RPOPL: begin
                asrc                = AS_STACK;
                r_d.pop[BYTE_W-1:0] = mem_rdata;
                r_d.st              = S_RINC2;
            end
            S_RINC2: begin
                r_d.sp = r_q.sp + 8'd1;
                r_d.st = S_RPOPH;
            end
            S_RPOPH: begin
                asrc                     = AS_STACK;
                r_d.pop[ADDR_W-1:BYTE_W] = mem_rdata;
                r_d.st                   = S_RADJ;
            end
            S_RADJ: begin
                r_d.pc = ret_sum;
                r_d.st = S_FIN;
            end
            S_FIN:   r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_RVL, pc: '0, sp: SP_INIT, tgt: '0, pop: '0, sel: '0,
                     idis: 1'b1, brk: 1'b0, ent: 1'b0, vsel: VS_RST};
        end else begin
            r_q <= r_d;
        end
    end

    assign pc      = r_q.pc;
    assign sp      = r_q.sp;
    assign idis    = r_q.idis;
    assign brk_sel = r_q.sel;
    assign busy    = (r_q.st != S_IDLE);
    assign done    = (r_q.st == S_FIN);
    assign st_w    = r_q.st;
endmodule

// File: rtl/callstack_seq_chk.sv
`timescale 1ns/1ps
module callstack_seq_chk
    import callstack_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STK_PAGE = 8'h01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] sp,
    input logic              done,
    input logic              idis,
    input logic              op_valid,
    input logic              nmi_take,
    input state_e            st
);
    // R11
    stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[ADDR_W-1:BYTE_W] == STK_PAGE);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_VECL || st == S_VECH || st == S_RVL || st == S_RVH)
            |-> &mem_addr[ADDR_W-1:VEC_LOW_W]);

    // R2
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp == $past(sp) - 8'd1);

    // R6
    idis_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PUSHP) |=> idis);

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && idis && !nmi_take && !op_valid) |=> st == S_IDLE);

    // R8
    nmi_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && nmi_take) |=> st == S_ENT);
endmodule

bind callstack_seq callstack_seq_chk #(.STK_PAGE(STK_PAGE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .sp       (sp),
    .done     (done),
    .idis     (idis),
    .op_valid (op_valid),
    .nmi_take (nmi_take),
    .st       (st_w)
);

// File: tb/callstack_seq_bench.sv
`timescale 1ns/1ps
module callstack_seq_bench;
    localparam logic [15:0] RST_VEC   = 16'hC000;
    localparam logic [15:0] IRQ_VEC   = 16'h8000;
    localparam logic [15:0] NMI_VEC   = 16'h9000;
    localparam logic [7:0]  CODE_BYTE = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [7:0]  opr_lo = 8'h00, opr_hi = 8'h00;
    logic        irq_n = 1'b1, nmi_n = 1'b1, idis_clr = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        idis;
    logic [7:0]  brk_sel;
    logic        busy, done;

    always #10 clk = ~clk;   // 50 MHz

    callstack_seq u_callstack_seq (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .opr_lo(opr_lo), .opr_hi(opr_hi), .irq_n(irq_n), .nmi_n(nmi_n),
        .idis_clr(idis_clr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .idis(idis),
        .brk_sel(brk_sel), .busy(busy), .done(done)
    );

    // memory model: stack page 1, six vector bytes, every other byte CODE_BYTE
    logic [7:0] stk [0:255];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) stk[i] <= 8'h00;
            stk[0] <= 8'h34;
            stk[1] <= 8'h12;
        end else if (mem_we && mem_addr[15:8] == 8'h01) begin
            stk[mem_addr[7:0]] <= mem_wdata;
        end
    end
    always_comb begin
        if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
        else begin
            case (mem_addr)
                16'hFFFA: mem_rdata = NMI_VEC[7:0];
                16'hFFFB: mem_rdata = NMI_VEC[15:8];
                16'hFFFC: mem_rdata = RST_VEC[7:0];
                16'hFFFD: mem_rdata = RST_VEC[15:8];
                16'hFFFE: mem_rdata = IRQ_VEC[7:0];
                16'hFFFF: mem_rdata = IRQ_VEC[15:8];
                default:  mem_rdata = CODE_BYTE;
            endcase
        end
    end

    // scoreboard
    typedef struct { logic [15:0] a; logic [7:0] d; string tag; } wr_t;
    typedef struct { logic [15:0] pc; logic [7:0] sp; int cyc; string tag; } fin_t;
    wr_t  wq[$];
    fin_t rq[$];
    int   nchk = 0, nfail = 0, bcnt = 0;

    logic [15:0] m_pc;
    logic [7:0]  m_sp;
    logic        m_idis;
    logic [7:0]  sh [0:255];

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic exp_push(input logic [7:0] d, input string tag);
        wr_t w;
        w.a = {8'h01, m_sp}; w.d = d; w.tag = tag;
        wq.push_back(w);
        sh[m_sp] = d;
        m_sp = m_sp - 8'd1;
    endtask

    task automatic exp_fin(input int cyc, input string tag);
        fin_t f;
        f.pc = m_pc; f.sp = m_sp; f.cyc = cyc; f.tag = tag;
        rq.push_back(f);
    endtask

    // monitor
    initial begin
        wr_t  w;
        fin_t f;
        forever begin
            @(posedge clk); #5;
            if (!rst_n) bcnt = 0;
            else begin
                if (mem_we) begin
                    if (wq.size() == 0) chk("R11", "unexpected write addr", {16'h0, mem_addr}, 32'hFFFF_FFFF);
                    else begin
                        w = wq.pop_front();
                        chk(w.tag, "write addr", {16'h0, mem_addr}, {16'h0, w.a});
                        chk(w.tag, "write data", {24'h0, mem_wdata}, {24'h0, w.d});
                    end
                end
                if (busy) bcnt++;
                if (done) begin
                    if (rq.size() == 0) chk("R11", "unexpected done", 32'd1, 32'd0);
                    else begin
                        f = rq.pop_front();
                        chk(f.tag, "pc", {16'h0, pc}, {16'h0, f.pc});
                        chk(f.tag, "sp", {24'h0, sp}, {24'h0, f.sp});
                        chk(f.tag, "busy cycles", bcnt, f.cyc);
                    end
                    bcnt = 0;
                end
            end
        end
    end

    task automatic wait_fin();
        while (rq.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] cls, input logic [15:0] tgt);
        @(negedge clk);
        op_valid = 1'b1; op_class = cls; opr_lo = tgt[7:0]; opr_hi = tgt[15:8];
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_call(input logic [15:0] tgt, input string tag);
        logic [15:0] ret;
        ret = m_pc + 16'd1;
        exp_push(ret[15:8], tag);
        exp_push(ret[7:0], tag);
        m_pc = tgt;
        exp_fin(6, tag);
        issue(2'd1, tgt);
        wait_fin();
    endtask

    task automatic do_ret(input string tag);
        logic [15:0] v;
        m_sp = m_sp + 8'd1; v[7:0]  = sh[m_sp];
        m_sp = m_sp + 8'd1; v[15:8] = sh[m_sp];
        m_pc = v + 16'd2;
        exp_fin(6, tag);
        issue(2'd2, 16'h0);
        wait_fin();
    endtask

    task automatic exp_entry(input logic [15:0] saved, input logic brk, input logic [15:0] vec, input string tag);
        exp_push(saved[15:8], tag);
        exp_push(saved[7:0], tag);
        exp_push(8'h20 | {3'b000, brk, 1'b0, m_idis, 2'b00}, tag);
        m_idis = 1'b1;
        m_pc = vec;
        exp_fin(7, tag);
    endtask

    task automatic quiet(input int n, input string tag);
        int c = 0;
        repeat (n) begin
            @(posedge clk); #5;
            if (busy) c++;
        end
        chk(tag, "busy cycles while quiet", c, 0);
        chk(tag, "pc unchanged", {16'h0, pc}, {16'h0, m_pc});
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) sh[i] = 8'h00;
        sh[0] = 8'h34; sh[1] = 8'h12;
        m_sp = 8'hFF; m_idis = 1'b1; m_pc = RST_VEC;

        // R1: reset state, then the reset vector fetch (2 busy samples)
        exp_fin(2, "R1");
        repeat (4) @(negedge clk);
        chk("R1", "sp in reset", {24'h0, sp}, 32'hFF);
        chk("R1", "idis in reset", {31'h0, idis}, 32'd1);
        rst_n = 1'b1;
        wait_fin();

        // R2: nested calls; the third saves 0x30FF for the carry case
        do_call(16'h20F0, "R2");
        do_call(16'h30FE, "R2");
        do_call(16'h4000, "R2");
        // R3: returns, the first carries low into high (0x30FF + 2 = 0x3101)
        do_ret("R3");
        do_ret("R3");
        do_ret("R3");
        // R4: pop at SP=FF reads 0x0100/0x0101, then push wraps to 0x0101/0x0100
        do_ret("R4");
        do_call(16'h5000, "R4");

        // R9: class 0 starts nothing
        issue(2'd0, 16'h1111);
        quiet(4, "R9");

        // R5: break reads selector at opcode+1, saves opcode+2
        exp_entry(m_pc + 16'd2, 1'b1, IRQ_VEC, "R5");
        issue(2'd3, 16'h0);
        wait_fin();
        chk("R5", "brk_sel", {24'h0, brk_sel}, {24'h0, CODE_BYTE});
        chk("R5", "idis after break", {31'h0, idis}, 32'd1);

        // R7: IRQ held low while masked
        irq_n = 1'b0;
        quiet(8, "R7");
        @(negedge clk); irq_n = 1'b1;

        // R10: clear the flag
        @(negedge clk); idis_clr = 1'b1;
        @(negedge clk); idis_clr = 1'b0;
        chk("R10", "idis after clear", {31'h0, idis}, 32'd0);
        m_idis = 1'b0;

        // R6: maskable entry
        exp_entry(m_pc, 1'b0, IRQ_VEC, "R6");
        @(negedge clk); irq_n = 1'b0;
        wait_fin();
        irq_n = 1'b1;
        chk("R6", "idis after irq", {31'h0, idis}, 32'd1);

        // R8: NMI and IRQ together, NMI wins
        @(negedge clk); idis_clr = 1'b1;
        @(negedge clk); idis_clr = 1'b0;
        m_idis = 1'b0;
        exp_entry(m_pc, 1'b0, NMI_VEC, "R8");
        @(negedge clk); irq_n = 1'b0; nmi_n = 1'b0;
        wait_fin();
        irq_n = 1'b1;
        // R8: held low, no second entry
        quiet(10, "R8");
        @(negedge clk); nmi_n = 1'b1;
        @(negedge clk);
        // R8: NMI taken with idis set
        exp_entry(m_pc, 1'b0, NMI_VEC, "R8");
        @(negedge clk); nmi_n = 1'b0;
        wait_fin();
        @(negedge clk); nmi_n = 1'b1;
        repeat (3) @(negedge clk);

        chk("R11", "pending writes left", wq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule